// File: doc/BRIEF.md
# Triggered Linked-List DMA Engine

This block is a single memory-to-memory DMA channel that works through a chain of descriptor nodes. The nodes sit in a small descriptor memory that software fills through a write port. Each node holds a source word address, a destination word address, a word count and a link to the next node. Software picks a head node and pulses a start input. The engine then loads that node and waits for a hardware trigger before it copies the node's block.

The trigger is a rising edge on one of 16 completion lines, chosen by a select input. Lines 0 to 7 carry channels 0 to 7 of the first upstream controller, and lines 8 to 15 carry channels 0 to 7 of the second. After the last data beat of each block, the engine writes a programmed mask to a programmed address on the same bus. This clears the upstream completion flag, so the two controllers can keep passing a shared buffer back and forth. The engine follows links until it reads a null link, and only then does it signal channel completion. A chain whose last node links back to an earlier node repeats until it is aborted.

Top module: `trig_list_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `busValid` and `chanDone` are all 0.
- R2: A start pulse while idle loads node `headIdx` and latches it. No bus cycle is issued until a trigger is seen. While idle, `busValid` stays 0.
- R3: Each block copies `len` words. Beat k reads address src+k and then, on the next cycle, writes that word to dst+k. Each read is followed at once by its write. A node with `len` = 0 moves no data.
- R4: One block runs per rising edge of `trigLines[trigSel]`, where the 4-bit index selects line 0..15 (0..7 = first upstream controller channels 0..7, 8..15 = second controller channels 0..7). Edges on other lines are ignored.
- R5: A trigger edge that arrives while a block is running is held pending and starts the next block without a further edge. This includes an edge in the same cycle that an earlier pending trigger is consumed.
- R6: After the last data beat of a block (or directly, for `len` = 0), the engine issues exactly one bus write of `ackMask` to `ackAddr`. The following cycle carries no bus access.
- R7: Descriptor index 0 is reserved and means a null link; nodes live at indices 1 to NODE_CNT-1. After the acknowledge of a node whose link is 0, the engine goes idle and `chanDone` pulses high for one cycle while `busy` is 0.
- R8: If the last node links back to an earlier node, the chain keeps serving triggers and `chanDone` is never raised.
- R9: A pulse on `abortReq` lets a data read already issued finish its write. Within two cycles the engine is then idle, with no `chanDone` and no acknowledge for the aborted block.
- R10: `prioLevel` is latched at start and driven on `busPrio` unchanged for the whole run, whatever the input does later.
- R11: A start pulse while the engine is busy has no effect on the running chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, takes effect only when idle |
| abortReq | input | 1 | Abort pulse |
| headIdx | input | IDX_W (3) | First descriptor index of the chain |
| prioLevel | input | PRIO_W (2) | Channel priority level, 3 is the highest |
| trigSel | input | SEL_W (4) | Index of the completion line used as trigger |
| trigLines | input | TRIG_LINES (16) | Upstream transfer-complete lines |
| ackAddr | input | ADDR_W (16) | Address of the upstream flag-clear register |
| ackMask | input | DATA_W (32) | Value written to clear the upstream flag |
| descWe | input | 1 | Descriptor write enable |
| descIdx | input | IDX_W (3) | Descriptor index to write |
| descSrc | input | ADDR_W (16) | Source word address of the node |
| descDst | input | ADDR_W (16) | Destination word address of the node |
| descLen | input | LEN_W (8) | Word count of the node |
| descLink | input | IDX_W (3) | Next node index, 0 = end of chain |
| busValid | output | 1 | Bus access this cycle |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W (16) | Bus word address |
| busWdata | output | DATA_W (32) | Write data |
| busRdata | input | DATA_W (32) | Read data, valid the cycle after a read |
| busPrio | output | PRIO_W (2) | Priority level latched for the run |
| busy | output | 1 | Engine is not idle |
| chanDone | output | 1 | One-cycle pulse when the whole chain has finished |

## Verification
Two things can fall in the same clock edge: the waiting state consuming a pending trigger, and a new edge arriving on the selected line. The bench causes this on purpose. It raises the trigger line together with the start pulse, drops it for one cycle, and raises it again at the exact edge where the engine leaves its wait state. The result is judged at the ports. The second node of a two-node chain must be copied without any further edge, and exactly two acknowledge writes and one completion pulse must appear. A design that lets consumption win over the new edge stalls before the second block.

// File: rtl/tld_pkg.sv
package tld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_ACK
  } tldState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setHead;
    logic loadNode;
    logic stepBeat;
    logic followLink;
    logic busRd;
    logic busWr;
    logic busAck;
  } tldStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lastBeat;
    logic lenZero;
    logic linkNull;
  } tldStatus_t;

endpackage

// File: rtl/tld_trig_capture.sv
module tld_trig_capture #(
  parameter int TRIG_LINES = 16,
  localparam int SEL_W = $clog2(TRIG_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TRIG_LINES-1:0] trigLines,
  input  logic [SEL_W-1:0]      trigSel,
  input  logic                  armed,
  input  logic                  consume,
  output logic                  pending
);

  logic [TRIG_LINES-1:0] prevLines;
  logic                  riseSeen;

  assign riseSeen = trigLines[trigSel] & ~prevLines[trigSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLines <= '0;
      pending   <= 1'b0;
    end else begin
      prevLines <= trigLines;
      if (!armed) pending <= 1'b0;
      else        pending <= riseSeen | (pending & ~consume);
    end
  end

endmodule

// File: rtl/tld_ctrl.sv
module tld_ctrl
  import tld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       abortReq,
  input  logic       pending,
  input  tldStatus_t status,
  output tldStrobe_t strobe,
  output logic       consume,
  output logic       armed,
  output logic       busy,
  output logic       chanDone
);

  tldState_e state, stateNxt;
  logic      abortPend;
  logic      abortHit;
  logic      doneSet;

  assign abortHit = abortReq | abortPend;
  assign busy     = (state != ST_IDLE);
  assign armed    = busy | startReq;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    consume  = 1'b0;
    doneSet  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.setHead = 1'b1;
          stateNxt       = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (abortHit) stateNxt = ST_IDLE;
        else begin
          strobe.loadNode = 1'b1;
          stateNxt        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (abortHit) stateNxt = ST_IDLE;
        else if (pending) begin
          consume  = 1'b1;
          stateNxt = status.lenZero ? ST_ACK : ST_READ;
        end
      end
      ST_READ: begin
        strobe.busRd = 1'b1;
        stateNxt     = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.busWr    = 1'b1;
        strobe.stepBeat = 1'b1;
        if (abortHit)             stateNxt = ST_IDLE;
        else if (status.lastBeat) stateNxt = ST_ACK;
        else                      stateNxt = ST_READ;
      end
      ST_ACK: begin
        strobe.busAck = 1'b1;
        if (abortHit) stateNxt = ST_IDLE;
        else if (status.linkNull) begin
          doneSet  = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          strobe.followLink = 1'b1;
          stateNxt          = ST_LOAD;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      abortPend <= 1'b0;
      chanDone  <= 1'b0;
    end else begin
      state    <= stateNxt;
      chanDone <= doneSet;
      if (state == ST_IDLE) abortPend <= 1'b0;
      else if (abortReq)    abortPend <= 1'b1;
    end
  end

endmodule

// File: rtl/tld_datapath.sv
module tld_datapath
  import tld_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int NODE_CNT = 8,
  parameter int PRIO_W   = 2,
  localparam int IDX_W   = $clog2(NODE_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tldStrobe_t        strobe,
  output tldStatus_t        status,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [PRIO_W-1:0] prioLevel,
  input  logic [ADDR_W-1:0] ackAddr,
  input  logic [DATA_W-1:0] ackMask,
  input  logic              descWe,
  input  logic [IDX_W-1:0]  descIdx,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [ADDR_W-1:0] descDst,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [IDX_W-1:0]  descLink,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [PRIO_W-1:0] busPrio
);

  logic [ADDR_W-1:0] nodeSrc  [NODE_CNT];
  logic [ADDR_W-1:0] nodeDst  [NODE_CNT];
  logic [LEN_W-1:0]  nodeLen  [NODE_CNT];
  logic [IDX_W-1:0]  nodeLink [NODE_CNT];

  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic [ADDR_W-1:0] srcPtr;
  logic [ADDR_W-1:0] dstPtr;
  logic [LEN_W-1:0]  remCnt;
  logic [PRIO_W-1:0] prioHeld;

  always_ff @(posedge clk) begin
    if (descWe) begin
      nodeSrc[descIdx]  <= descSrc;
      nodeDst[descIdx]  <= descDst;
      nodeLen[descIdx]  <= descLen;
      nodeLink[descIdx] <= descLink;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      nextIdx  <= '0;
      srcPtr   <= '0;
      dstPtr   <= '0;
      remCnt   <= '0;
      prioHeld <= '0;
    end else begin
      if (strobe.setHead) begin
        curIdx   <= headIdx;
        prioHeld <= prioLevel;
      end
      if (strobe.loadNode) begin
        srcPtr  <= nodeSrc[curIdx];
        dstPtr  <= nodeDst[curIdx];
        remCnt  <= nodeLen[curIdx];
        nextIdx <= nodeLink[curIdx];
      end
      if (strobe.stepBeat) begin
        srcPtr <= srcPtr + 1'b1;
        dstPtr <= dstPtr + 1'b1;
        remCnt <= remCnt - 1'b1;
      end
      if (strobe.followLink) curIdx <= nextIdx;
    end
  end

  assign status.lastBeat = (remCnt == LEN_W'(1));
  assign status.lenZero  = (remCnt == '0);
  assign status.linkNull = (nextIdx == '0);

  assign busValid = strobe.busRd | strobe.busWr | strobe.busAck;
  assign busWrite = strobe.busWr | strobe.busAck;
  assign busAddr  = strobe.busAck ? ackAddr : (strobe.busWr ? dstPtr : srcPtr);
  assign busWdata = strobe.busAck ? ackMask : busRdata;
  assign busPrio  = prioHeld;

endmodule

// File: rtl/trig_list_dma.sv
module trig_list_dma
  import tld_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  parameter int NODE_CNT   = 8,
  parameter int TRIG_LINES = 16,
  parameter int PRIO_W     = 2,
  localparam int IDX_W     = $clog2(NODE_CNT),
  localparam int SEL_W     = $clog2(TRIG_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  abortReq,
  input  logic [IDX_W-1:0]      headIdx,
  input  logic [PRIO_W-1:0]     prioLevel,
  input  logic [SEL_W-1:0]      trigSel,
  input  logic [TRIG_LINES-1:0] trigLines,
  input  logic [ADDR_W-1:0]     ackAddr,
  input  logic [DATA_W-1:0]     ackMask,
  input  logic                  descWe,
  input  logic [IDX_W-1:0]      descIdx,
  input  logic [ADDR_W-1:0]     descSrc,
  input  logic [ADDR_W-1:0]     descDst,
  input  logic [LEN_W-1:0]      descLen,
  input  logic [IDX_W-1:0]      descLink,
  output logic                  busValid,
  output logic                  busWrite,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W-1:0]     busRdata,
  output logic [PRIO_W-1:0]     busPrio,
  output logic                  busy,
  output logic                  chanDone
);

  tldStrobe_t strobe;
  tldStatus_t status;
  logic       pending;
  logic       consume;
  logic       armed;

  tld_trig_capture #(.TRIG_LINES(TRIG_LINES)) u_trig (
    .clk(clk), .rstN(rstN), .trigLines(trigLines), .trigSel(trigSel),
    .armed(armed), .consume(consume), .pending(pending)
  );

  tld_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .pending(pending), .status(status), .strobe(strobe), .consume(consume),
    .armed(armed), .busy(busy), .chanDone(chanDone)
  );

  tld_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .NODE_CNT(NODE_CNT), .PRIO_W(PRIO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .headIdx(headIdx), .prioLevel(prioLevel), .ackAddr(ackAddr),
    .ackMask(ackMask), .descWe(descWe), .descIdx(descIdx),
    .descSrc(descSrc), .descDst(descDst), .descLen(descLen),
    .descLink(descLink), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busPrio(busPrio)
  );

endmodule

// File: rtl/tld_checker.sv
module tld_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              abortReq,
  input logic [ADDR_W-1:0] ackAddr,
  input logic [DATA_W-1:0] ackMask,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [PRIO_W-1:0] busPrio,
  input logic              busy,
  input logic              chanDone
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busValid);

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> (busValid && busWrite));

  // R6
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ackAddr && busWdata == ackMask) |=> !busValid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanDone |=> !chanDone);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanDone |-> !busy);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> ##1 !busy);

  // R10
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(busPrio)));

endmodule

bind trig_list_dma tld_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rstN(rstN), .abortReq(abortReq), .ackAddr(ackAddr),
  .ackMask(ackMask), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busPrio(busPrio),
  .busy(busy), .chanDone(chanDone)
);

// File: tb/trig_list_dma_test.sv
`timescale 1ns/1ps
module trig_list_dma_test;

  localparam logic [15:0] ACK_ADR = 16'h8000;
  localparam logic [31:0] ACK_VAL = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, abortReq = 1'b0;
  logic [2:0]  headIdx = '0;
  logic [1:0]  prioLevel = 2'd1;
  logic [3:0]  trigSel = '0;
  logic [15:0] trigLines = '0;
  logic        descWe = 1'b0;
  logic [2:0]  descIdx = '0, descLink = '0;
  logic [15:0] descSrc = '0, descDst = '0;
  logic [7:0]  descLen = '0;
  logic        busValid, busWrite, busy, chanDone;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic [1:0]  busPrio;

  logic [31:0] mem [256];
  int checkCount = 0, failCount = 0;
  int ackCount = 0, doneCount = 0, dataWrites = 0, prioErr = 0;
  logic [31:0] lastAck = '0;
  logic [1:0]  expPrio = 2'd1;

  always #2 clk = ~clk;

  trig_list_dma uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .headIdx(headIdx), .prioLevel(prioLevel), .trigSel(trigSel),
    .trigLines(trigLines), .ackAddr(ACK_ADR), .ackMask(ACK_VAL),
    .descWe(descWe), .descIdx(descIdx), .descSrc(descSrc), .descDst(descDst),
    .descLen(descLen), .descLink(descLink), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busPrio(busPrio), .busy(busy), .chanDone(chanDone)
  );

  // memory model and bus monitors
  always @(posedge clk) begin
    if (rstN && busValid) begin
      if (busPrio != expPrio) prioErr <= prioErr + 1;
      if (!busWrite) busRdata <= mem[busAddr[7:0]];
      else if (busAddr == ACK_ADR) begin
        ackCount <= ackCount + 1;
        lastAck  <= busWdata;
      end else begin
        dataWrites <= dataWrites + 1;
        mem[busAddr[7:0]] <= busWdata;
      end
    end
    if (rstN && chanDone) doneCount <= doneCount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeNode(input int idx, input int src, input int dst,
                           input int len, input int link);
    @(negedge clk);
    descWe = 1'b1; descIdx = 3'(idx); descSrc = 16'(src);
    descDst = 16'(dst); descLen = 8'(len); descLink = 3'(link);
    @(negedge clk);
    descWe = 1'b0;
  endtask

  task automatic startAt(input int idx);
    @(negedge clk);
    headIdx = 3'(idx); prioLevel = expPrio; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic pulseLine(input int line);
    @(negedge clk);
    trigLines[line] = 1'b1;
    @(negedge clk);
    trigLines[line] = 1'b0;
  endtask

  function automatic int copyErrors(input int src, input int dst, input int len);
    int errs = 0;
    for (int k = 0; k < len; k++)
      if (mem[dst + k] != 32'hA000 + 32'(src + k)) errs++;
    return errs;
  endfunction

  task automatic testReset();
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(busValid == 1'b0, "R1", "busValid after reset", busValid, 0);
    check(chanDone == 1'b0, "R1", "chanDone after reset", chanDone, 0);
  endtask

  task automatic testSingleNode();
    int a0 = ackCount, d0 = doneCount;
    writeNode(1, 'h10, 'h40, 4, 0);
    trigSel = 4'd3;
    startAt(1);
    waitCyc(10);
    check(mem['h40] == 32'hA040, "R2", "no copy before trigger", mem['h40], 32'hA040);
    check(busy == 1'b1, "R2", "waiting busy", busy, 1);
    pulseLine(5);
    waitCyc(10);
    check(mem['h40] == 32'hA040, "R4", "unselected line ignored", mem['h40], 32'hA040);
    pulseLine(3);
    waitCyc(20);
    check(copyErrors('h10, 'h40, 4) == 0, "R3", "block copy errors", copyErrors('h10, 'h40, 4), 0);
    check(mem['h44] == 32'hA044, "R3", "word past block untouched", mem['h44], 32'hA044);
    check(ackCount == a0 + 1, "R6", "ack count", ackCount, a0 + 1);
    check(lastAck == ACK_VAL, "R6", "ack data", lastAck, ACK_VAL);
    check(doneCount == d0 + 1, "R7", "done pulses", doneCount, d0 + 1);
    check(busy == 1'b0, "R7", "idle after null link", busy, 0);
  endtask

  task automatic testPendingAndPrio();
    int a0 = ackCount, d0 = doneCount;
    writeNode(2, 'h20, 'h60, 6, 3);
    writeNode(3, 'h30, 'h70, 3, 0);
    trigSel = 4'd12;
    expPrio = 2'd2;
    startAt(2);
    @(negedge clk); prioLevel = 2'd0;
    waitCyc(3);
    pulseLine(12);
    waitCyc(3);
    pulseLine(12);
    @(negedge clk); headIdx = 3'd1; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    waitCyc(60);
    check(copyErrors('h20, 'h60, 6) == 0, "R4", "second controller line block", copyErrors('h20, 'h60, 6), 0);
    check(copyErrors('h30, 'h70, 3) == 0, "R5", "pending trigger ran node 3", copyErrors('h30, 'h70, 3), 0);
    check(ackCount == a0 + 2, "R11", "busy start ignored, ack count", ackCount, a0 + 2);
    check(doneCount == d0 + 1, "R7", "single done for chain", doneCount, d0 + 1);
    check(prioErr == 0, "R10", "priority held for run", prioErr, 0);
    expPrio = 2'd1;
  endtask

  task automatic testCoincident();
    int a0 = ackCount, d0 = doneCount;
    writeNode(4, 'h80, 'h90, 2, 5);
    writeNode(5, 'h84, 'h94, 2, 0);
    trigSel = 4'd7;
    @(negedge clk);
    headIdx = 3'd4; prioLevel = expPrio; startReq = 1'b1; trigLines[7] = 1'b1;
    @(negedge clk);
    startReq = 1'b0; trigLines[7] = 1'b0;
    @(negedge clk);
    trigLines[7] = 1'b1;
    @(negedge clk);
    trigLines[7] = 1'b0;
    waitCyc(30);
    check(copyErrors('h84, 'h94, 2) == 0, "R5", "edge at consume kept", copyErrors('h84, 'h94, 2), 0);
    check(ackCount == a0 + 2, "R5", "ack count coincident", ackCount, a0 + 2);
    check(doneCount == d0 + 1, "R7", "done coincident", doneCount, d0 + 1);
  endtask

  task automatic testZeroLen();
    int a0 = ackCount, d0 = doneCount, w0 = dataWrites;
    writeNode(6, 'h10, 'hB0, 0, 0);
    trigSel = 4'd0;
    startAt(6);
    waitCyc(3);
    pulseLine(0);
    waitCyc(10);
    check(dataWrites == w0, "R3", "zero length moves no data", dataWrites, w0);
    check(ackCount == a0 + 1, "R6", "zero length still acks", ackCount, a0 + 1);
    check(doneCount == d0 + 1, "R7", "zero length done", doneCount, d0 + 1);
  endtask

  task automatic testLoopAbort();
    int a0 = ackCount, d0 = doneCount;
    writeNode(6, 'h50, 'hA0, 1, 7);
    writeNode(7, 'h52, 'hA4, 2, 6);
    trigSel = 4'd9;
    startAt(6);
    waitCyc(3);
    for (int t = 0; t < 5; t++) begin
      pulseLine(9);
      waitCyc(20);
    end
    check(ackCount == a0 + 5, "R8", "loop acks per trigger", ackCount, a0 + 5);
    check(doneCount == d0, "R8", "loop never done", doneCount, d0);
    check(busy == 1'b1, "R8", "loop still busy", busy, 1);
    @(negedge clk); abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    waitCyc(5);
    check(busy == 1'b0, "R9", "abort idles loop", busy, 0);
    check(doneCount == d0, "R9", "abort raises no done", doneCount, d0);
  endtask

  task automatic testAbortMid();
    int a0 = ackCount, d0 = doneCount;
    writeNode(1, 'h10, 'hC0, 20, 0);
    trigSel = 4'd2;
    startAt(1);
    waitCyc(3);
    pulseLine(2);
    waitCyc(8);
    @(negedge clk); abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    waitCyc(10);
    check(busy == 1'b0, "R9", "abort mid block idle", busy, 0);
    check(mem['hC0] == 32'hA010, "R9", "beats before abort done", mem['hC0], 32'hA010);
    check(mem['hD3] == 32'hA0D3, "R9", "last word not copied", mem['hD3], 32'hA0D3);
    check(ackCount == a0, "R9", "no ack after abort", ackCount, a0);
    check(doneCount == d0, "R9", "no done after abort", doneCount, d0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000 + 32'(i);
    waitCyc(4);
    @(negedge clk); rstN = 1'b1;
    waitCyc(1);
    testReset();
    testSingleNode();
    testPendingAndPrio();
    testCoincident();
    testZeroLen();
    testLoopAbort();
    testAbortMid();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule